// File: doc/BRIEF.md
# Write-Protect Unlock Sequence Detector

This block guards a byte-wide nonvolatile region against stray writes. It watches every host write strobe together with its address and data. While the region is locked, every write toward the storage array is refused. A fixed six-write command sequence, presented in order, unlocks the region.

The unlock does not take effect at once. After the final command write, the block holds a busy indication for a settling time of a parameterised number of clock cycles. Only when that time has elapsed does the locked state clear. From then on, every write strobe is forwarded to the page write logic through the write-allow output.

The detector has no timeout between steps: idle cycles may separate the command writes. Any write that does not fit the expected step sends the detector back to the start. That same write is then judged again as a possible first step.

Top module: `wp_unlock_seq`

## Requirements
- R1: After reset, `locked_o` is 1, `busy_o` is 0 and `wr_ok_o` is 0.
- R2: While `locked_o` is 1, `wr_ok_o` is 0 for every write, command writes included.
- R3: Six strobed writes (address:data) in this exact order start the settling period: 5555h:AAh, 2AAAh:55h, 5555h:80h, 5555h:AAh, 2AAAh:55h, 5555h:20h. `busy_o` rises in the cycle after the sixth write.
- R4: Only address bits 14..0 are compared. A command write with bit 15 set still counts as its step.
- R5: A write that fits neither the expected step nor the first step returns the detector to the start. Idle cycles between steps do not disturb progress.
- R6: A write that breaks the sequence but equals the first step (5555h:AAh) is counted as the first step of a new attempt.
- R7: `busy_o` stays 1 for exactly TWC_CYCLES cycles. `locked_o` stays 1 throughout that time and falls in the same cycle that `busy_o` falls.
- R8: Once unlocked, `wr_ok_o` equals `wr_en` in the same cycle, and the block never relocks before reset.
- R9: If a sixth step is captured on the last busy cycle, the settling counter reloads. `busy_o` then stays 1 for TWC_CYCLES more cycles, and `locked_o` stays 1 until those cycles end.
- R10: Address and data presented with `wr_en` low have no effect on the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host write strobe, one write per cycle held high |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data |
| locked_o | output | 1 | 1 while writes to storage are blocked |
| wr_ok_o | output | 1 | Write forwarded to page write logic |
| busy_o | output | 1 | Settling period after a completed sequence |

## Verification
Two functions can land in the same cycle: the settling counter expiring, and a new sixth command step being captured. To provoke this, a second full sequence is timed so that its last write meets the final busy cycle. The test passes only if busy continues for a full further period and the lock holds until that period ends. A second collision is exercised as well: a broken sequence where the offending write is itself a first step. The test judges that case by whether the remaining five steps still unlock the region.

// File: rtl/wp_unlock_seq.sv
module wp_unlock_seq #(
  parameter int unsigned ADDR_W     = 16,
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned TWC_CYCLES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              locked_o,
  output logic              wr_ok_o,
  output logic              busy_o
);
  localparam int unsigned CMP_W  = 15;
  localparam int unsigned CNT_W  = $clog2(TWC_CYCLES + 1);
  localparam int unsigned LAST   = 5;
  localparam logic [CMP_W-1:0] A_HI = 15'h5555;
  localparam logic [CMP_W-1:0] A_LO = 15'h2AAA;

  function automatic logic [CMP_W-1:0] step_addr(input logic [2:0] s);
    case (s)
      3'd1, 3'd4: step_addr = A_LO;
      default:    step_addr = A_HI;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] step_data(input logic [2:0] s);
    case (s)
      3'd0, 3'd3: step_data = DATA_W'(8'hAA);
      3'd1, 3'd4: step_data = DATA_W'(8'h55);
      3'd2:       step_data = DATA_W'(8'h80);
      default:    step_data = DATA_W'(8'h20);
    endcase
  endfunction

  logic [2:0]       step_q;
  logic [CNT_W-1:0] tmr_q;
  logic             lock_q;

  wire [CMP_W-1:0] a_cmp  = wr_addr[CMP_W-1:0];
  wire hit_step  = wr_en && a_cmp == step_addr(step_q) && wr_data == step_data(step_q);
  wire hit_first = wr_en && a_cmp == A_HI && wr_data == step_data(3'd0);
  wire seq_done  = hit_step && step_q == 3'(LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      step_q <= '0;
    end else if (wr_en) begin
      if (hit_step)       step_q <= seq_done ? 3'd0 : step_q + 3'd1;
      else if (hit_first) step_q <= 3'd1;
      else                step_q <= 3'd0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tmr_q  <= '0;
      lock_q <= 1'b1;
    end else begin
      if (seq_done)           tmr_q <= CNT_W'(TWC_CYCLES);
      else if (tmr_q != '0)   tmr_q <= tmr_q - CNT_W'(1);
      if (!seq_done && tmr_q == CNT_W'(1)) lock_q <= 1'b0;
    end
  end

  assign locked_o = lock_q;
  assign busy_o   = tmr_q != '0;
  assign wr_ok_o  = wr_en && !lock_q;
endmodule

// File: rtl/wp_unlock_seq_chk.sv
module wp_unlock_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic wr_en,
  input logic locked_o,
  input logic wr_ok_o,
  input logic busy_o
);
  p_reset_state_r1: assert property (@(posedge clk)
    $rose(rst_n) |-> locked_o && !busy_o);

  p_block_locked_r2: assert property (@(posedge clk) disable iff (!rst_n)
    locked_o |-> !wr_ok_o);

  p_busy_after_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(wr_en));

  p_unlock_at_busy_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(locked_o) |-> $fell(busy_o));

  p_no_relock_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !locked_o |=> !locked_o);
endmodule

bind wp_unlock_seq wp_unlock_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en),
  .locked_o(locked_o), .wr_ok_o(wr_ok_o), .busy_o(busy_o)
);

// File: tb/wp_unlock_seq_tb.sv
module wp_unlock_seq_tb;
  localparam int TWC = 8;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        wr_en = 0;
  logic [15:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        locked_o, wr_ok_o, busy_o;
  int total = 0, bad = 0;
  logic last_ok;

  always #5 clk = ~clk;

  wp_unlock_seq #(.ADDR_W(16), .DATA_W(8), .TWC_CYCLES(TWC)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .locked_o(locked_o), .wr_ok_o(wr_ok_o), .busy_o(busy_o)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0b expected=%0b t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0; wr_en = 0;
    @(negedge clk); @(negedge clk); rst_n = 1;
  endtask

  task automatic send(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    #1 last_ok = wr_ok_o;
  endtask

  task automatic idle();
    @(negedge clk); wr_en = 0;
    #1;
  endtask

  task automatic steps(input int from, input int upto, input logic [15:0] hi, input int gap);
    logic [15:0] a [6];
    logic [7:0]  d [6];
    a = '{16'h5555, 16'h2AAA, 16'h5555, 16'h5555, 16'h2AAA, 16'h5555};
    d = '{8'hAA, 8'h55, 8'h80, 8'hAA, 8'h55, 8'h20};
    for (int i = from; i <= upto; i++) begin
      send(a[i] | hi, d[i]);
      if (i != upto) for (int g = 0; g < gap; g++) idle();
    end
  endtask

  task automatic t_reset();
    do_reset();
    #1;
    chk("R1 locked", locked_o, 1'b1);
    chk("R1 busy", busy_o, 1'b0);
    chk("R1 wr_ok", wr_ok_o, 1'b0);
  endtask

  task automatic t_blocked();
    do_reset();
    send(16'h1234, 8'h5A);
    chk("R2 plain write blocked", last_ok, 1'b0);
    steps(0, 2, 16'h0, 0);
    chk("R2 command write blocked", last_ok, 1'b0);
    idle();
    chk("R2 still locked", locked_o, 1'b1);
  endtask

  task automatic t_wrong_order();
    do_reset();
    steps(0, 1, 16'h0, 0);
    send(16'h2AAA, 8'hAA);
    steps(2, 5, 16'h0, 0);
    idle();
    chk("R5 broken sequence no busy", busy_o, 1'b0);
    repeat (TWC + 2) idle();
    chk("R5 broken sequence stays locked", locked_o, 1'b1);
  endtask

  task automatic t_strobe_low();
    do_reset();
    steps(0, 0, 16'h0, 0);
    @(negedge clk); wr_en = 0; wr_addr = 16'h2AAA; wr_data = 8'h55;
    steps(2, 5, 16'h0, 0);
    idle();
    chk("R10 unstrobed bus ignored", busy_o, 1'b0);
  endtask

  task automatic t_restart();
    do_reset();
    steps(0, 1, 16'h0, 0);
    send(16'h5555, 8'hAA);
    steps(1, 5, 16'h0, 0);
    idle();
    chk("R6 breaking write counted as step one", busy_o, 1'b1);
  endtask

  task automatic t_high_bit();
    do_reset();
    steps(0, 5, 16'h8000, 2);
    idle();
    chk("R4 bit15 ignored, R5 gaps allowed", busy_o, 1'b1);
  endtask

  task automatic t_timing();
    do_reset();
    steps(0, 5, 16'h0, 0);
    idle();
    for (int c = 0; c < TWC; c++) begin
      chk("R7 busy during settle", busy_o, 1'b1);
      chk("R7 locked during settle", locked_o, 1'b1);
      if (c != TWC - 1) idle();
    end
    idle();
    chk("R7 busy ends", busy_o, 1'b0);
    chk("R7 unlocked", locked_o, 1'b0);
    send(16'h0042, 8'h11);
    chk("R8 write allowed", last_ok, 1'b1);
    idle();
    chk("R8 no strobe no allow", wr_ok_o, 1'b0);
    repeat (4) idle();
    chk("R8 stays unlocked", locked_o, 1'b0);
  endtask

  task automatic t_overlap();
    do_reset();
    steps(0, 5, 16'h0, 0);
    idle();
    idle();
    steps(0, 5, 16'h0, 0);
    idle();
    for (int c = 0; c < TWC; c++) begin
      chk("R9 busy extended", busy_o, 1'b1);
      chk("R9 lock held", locked_o, 1'b1);
      if (c != TWC - 1) idle();
    end
    idle();
    chk("R9 busy ends after reload", busy_o, 1'b0);
    chk("R9 unlocked after reload", locked_o, 1'b0);
  endtask

  initial begin
    #1_000_000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_blocked();
    t_wrong_order();
    t_strobe_low();
    t_restart();
    t_high_bit();
    t_timing();
    t_overlap();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule